// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the serial test port of a device. A tester drives a test clock, a mode-select line and a serial data input, and reads a serial data output. On each rising test-clock edge the controller steps through the standard sixteen-state sequencer using the mode-select value. The two scan branches of that sequencer move a 3-bit instruction register or the data register that the current instruction selects. Each register is captured, shifted least significant bit first, and then updated.

The data registers are a 32-bit identification register, a 1-bit bypass register and a boundary register whose length is a parameter. The pin boundary is modelled in two parts. A parallel input vector is sampled on capture. A parallel output vector holds the last pattern written on update. Two decoded controls leave the block. One tells the pad ring to drive the boundary pattern during external test. The other forces every functional output driver to high impedance while the high-impedance sample instruction is active.

Serial output changes only on falling test-clock edges. Its enable is raised only while a shift state is active.

Top module: `scan_tap_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, the sequencer is in Test-Logic-Reset. In that state `tdo_oe`, `out_hiz`, `ext_drive` and `pins_out` are all 0. From Test-Logic-Reset, a rising edge with `tms` = 0 enters Run-Test/Idle.
- R2: Five consecutive rising edges with `tms` = 1 reach Test-Logic-Reset from any state.
- R3: The sequencer follows the standard transitions on `tms` through the data and instruction branches: Select, Capture, Shift, Exit1, Pause, Exit2 and Update.
- R4: The instruction register is 3 bits and shifts in least significant bit first during Shift-IR. The value 3'b001 is captured in Capture-IR and shifted out. A new code takes effect only on the rising edge that leaves Update-IR.
- R5: Code 3'b001 (identification) selects the 32-bit identification register. It captures the `ID_VAL` parameter, which is shifted out least significant bit first.
- R6: Code 3'b010 (high-impedance sample) selects the boundary register, which captures `pins_in`. It holds `out_hiz` at 1 for as long as it is the current instruction. Every other code leaves `out_hiz` at 0.
- R7: Code 3'b100 (sample/preload) selects the boundary register, which captures `pins_in`. For any code that selects the boundary register, the shifted pattern is copied to `pins_out` on the rising edge that leaves Update-DR.
- R8: Code 3'b000 (external test) selects the boundary register and holds `ext_drive` at 1. Every other code leaves `ext_drive` at 0.
- R9: Codes 3'b111, 3'b011, 3'b101 and 3'b110 select the 1-bit bypass register. It captures 0 and delays `tdi` by one shift. `pins_out` keeps its value while bypass is selected.
- R10: `tdo` and `tdo_oe` change only after falling edges of `tck`. `tdo_oe` is 1 exactly while the sequencer is in Shift-DR or Shift-IR.
- R11: Entering Test-Logic-Reset makes 3'b001 the current instruction again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tms | input | 1 | Mode select, sampled on rising tck |
| tdi | input | 1 | Serial data in, sampled on rising tck |
| pins_in | input | BSR_LEN | Parallel pin values captured into the boundary register |
| tdo | output | 1 | Serial data out, changes on falling tck |
| tdo_oe | output | 1 | Output enable for tdo |
| pins_out | output | BSR_LEN | Boundary pattern written on update |
| out_hiz | output | 1 | Force functional outputs to high impedance |
| ext_drive | output | 1 | Drive pins from the boundary pattern |

## Verification
A `tms` value takes effect in the state on the following rising edge. The bench therefore drives `tms` and `tdi` while `tck` is low, and reads `tdo` and `tdo_oe` 1 ns after the next falling edge. The first captured bit appears after the falling edge that follows the rising edge entering a shift state. Each further bit appears one cycle later, so a register of N bits is read over N steps. Decoded controls change one rising edge after Update-IR, and `pins_out` changes one rising edge after Update-DR, so the bench checks both only after the step into Run-Test/Idle. It also reads `tdo` just before and just after each rising edge to confirm that the edge does not change it.

// File: rtl/tap_pkg.sv
package tap_pkg;

    localparam int IR_W = 3;
    localparam int ID_W = 32;

    localparam logic [IR_W-1:0] OP_EXTEST  = 3'b000;
    localparam logic [IR_W-1:0] OP_IDCODE  = 3'b001;
    localparam logic [IR_W-1:0] OP_SAMPLEZ = 3'b010;
    localparam logic [IR_W-1:0] OP_PRELOAD = 3'b100;
    localparam logic [IR_W-1:0] OP_BYPASS  = 3'b111;
    localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

    typedef enum logic [3:0] {
        TS_RESET, TS_IDLE,
        TS_SEL_DR, TS_CAP_DR, TS_SHF_DR, TS_EX1_DR, TS_PAU_DR, TS_EX2_DR, TS_UPD_DR,
        TS_SEL_IR, TS_CAP_IR, TS_SHF_IR, TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR
    } tap_state_e;

    typedef enum logic [1:0] {
        SEL_BYP,
        SEL_ID,
        SEL_BSR
    } dr_sel_e;

    function automatic dr_sel_e op_to_sel(input logic [IR_W-1:0] op);
        dr_sel_e s;
        case (op)
            OP_EXTEST, OP_SAMPLEZ, OP_PRELOAD: s = SEL_BSR;
            OP_IDCODE:                         s = SEL_ID;
            default:                           s = SEL_BYP;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  logic       tms,
    output tap_state_e state
);

    typedef struct packed {
        tap_state_e st;
    } fsm_t;

    fsm_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        case (cur_q.st)
            TS_RESET:  nxt_d.st = tms ? TS_RESET  : TS_IDLE;
            TS_IDLE:   nxt_d.st = tms ? TS_SEL_DR : TS_IDLE;
            TS_SEL_DR: nxt_d.st = tms ? TS_SEL_IR : TS_CAP_DR;
            TS_CAP_DR: nxt_d.st = tms ? TS_EX1_DR : TS_SHF_DR;
            TS_SHF_DR: nxt_d.st = tms ? TS_EX1_DR : TS_SHF_DR;
            TS_EX1_DR: nxt_d.st = tms ? TS_UPD_DR : TS_PAU_DR;
            TS_PAU_DR: nxt_d.st = tms ? TS_EX2_DR : TS_PAU_DR;
            TS_EX2_DR: nxt_d.st = tms ? TS_UPD_DR : TS_SHF_DR;
            TS_UPD_DR: nxt_d.st = tms ? TS_SEL_DR : TS_IDLE;
            TS_SEL_IR: nxt_d.st = tms ? TS_RESET  : TS_CAP_IR;
            TS_CAP_IR: nxt_d.st = tms ? TS_EX1_IR : TS_SHF_IR;
            TS_SHF_IR: nxt_d.st = tms ? TS_EX1_IR : TS_SHF_IR;
            TS_EX1_IR: nxt_d.st = tms ? TS_UPD_IR : TS_PAU_IR;
            TS_PAU_IR: nxt_d.st = tms ? TS_EX2_IR : TS_PAU_IR;
            TS_EX2_IR: nxt_d.st = tms ? TS_UPD_IR : TS_SHF_IR;
            TS_UPD_IR: nxt_d.st = tms ? TS_SEL_DR : TS_IDLE;
            default:   nxt_d.st = TS_RESET;
        endcase
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) cur_q <= '{st: TS_RESET};
        else        cur_q <= nxt_d;
    end

    assign state = cur_q.st;

endmodule

// File: rtl/tap_ir.sv
module tap_ir
    import tap_pkg::*;
(
    input  logic            tck,
    input  logic            rst_n,
    input  logic            tdi,
    input  tap_state_e      state,
    output logic [IR_W-1:0] ir_code,
    output logic            ir_lsb,
    output dr_sel_e         dr_sel,
    output logic            hiz,
    output logic            extest
);

    typedef struct packed {
        logic [IR_W-1:0] sr;
        logic [IR_W-1:0] ir;
    } ir_t;

    ir_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        case (state)
            TS_RESET:  nxt_d.ir = OP_IDCODE;
            TS_CAP_IR: nxt_d.sr = IR_CAPTURE;
            TS_SHF_IR: nxt_d.sr = {tdi, cur_q.sr[IR_W-1:1]};
            TS_UPD_IR: nxt_d.ir = cur_q.sr;
            default:   ;
        endcase
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) cur_q <= '{sr: IR_CAPTURE, ir: OP_IDCODE};
        else        cur_q <= nxt_d;
    end

    assign ir_code = cur_q.ir;
    assign ir_lsb  = cur_q.sr[0];
    assign dr_sel  = op_to_sel(cur_q.ir);
    assign hiz     = (cur_q.ir == OP_SAMPLEZ);
    assign extest  = (cur_q.ir == OP_EXTEST);

endmodule

// File: rtl/tap_dr.sv
module tap_dr
    import tap_pkg::*;
#(
    parameter int          BSR_LEN = 109,
    parameter logic [31:0] ID_VAL  = 32'h0BAD_C0DF
) (
    input  logic               tck,
    input  logic               rst_n,
    input  logic               tdi,
    input  tap_state_e         state,
    input  dr_sel_e            dr_sel,
    input  logic [BSR_LEN-1:0] pins_in,
    output logic               dr_lsb,
    output logic [BSR_LEN-1:0] pins_out
);

    localparam int SR_W = (BSR_LEN > ID_W) ? BSR_LEN : ID_W;

    typedef struct packed {
        logic [SR_W-1:0]    sr;
        logic [BSR_LEN-1:0] upd;
    } dr_t;

    dr_t             cur_q, nxt_d;
    int              sel_len;
    logic [SR_W-1:0] down;

    always_comb begin
        case (dr_sel)
            SEL_BSR: sel_len = BSR_LEN;
            SEL_ID:  sel_len = ID_W;
            default: sel_len = 1;
        endcase
    end

    assign down = {1'b0, cur_q.sr[SR_W-1:1]};

    always_comb begin
        nxt_d = cur_q;
        case (state)
            TS_CAP_DR: begin
                nxt_d.sr = '0;
                if (dr_sel == SEL_BSR)     nxt_d.sr[BSR_LEN-1:0] = pins_in;
                else if (dr_sel == SEL_ID) nxt_d.sr[ID_W-1:0]    = ID_VAL;
            end
            TS_SHF_DR: begin
                for (int i = 0; i < SR_W; i++) begin
                    if (i == sel_len - 1)    nxt_d.sr[i] = tdi;
                    else if (i < sel_len - 1) nxt_d.sr[i] = down[i];
                end
            end
            TS_UPD_DR: begin
                if (dr_sel == SEL_BSR) nxt_d.upd = cur_q.sr[BSR_LEN-1:0];
            end
            default: ;
        endcase
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign dr_lsb   = cur_q.sr[0];
    assign pins_out = cur_q.upd;

endmodule

// File: rtl/scan_tap_ctrl.sv
module scan_tap_ctrl
    import tap_pkg::*;
#(
    parameter int          BSR_LEN = 109,
    parameter logic [31:0] ID_VAL  = 32'h0BAD_C0DF
) (
    input  logic               tck,
    input  logic               rst_n,
    input  logic               tms,
    input  logic               tdi,
    input  logic [BSR_LEN-1:0] pins_in,
    output logic               tdo,
    output logic               tdo_oe,
    output logic [BSR_LEN-1:0] pins_out,
    output logic               out_hiz,
    output logic               ext_drive
);

    typedef struct packed {
        logic tdo;
        logic oe;
    } out_t;

    tap_state_e      state;
    logic [IR_W-1:0] ir_code;
    logic            ir_lsb;
    logic            dr_lsb;
    dr_sel_e         dr_sel;
    out_t            out_q, out_d;

    tap_fsm u_fsm (
        .tck   (tck),
        .rst_n (rst_n),
        .tms   (tms),
        .state (state)
    );

    tap_ir u_ir (
        .tck     (tck),
        .rst_n   (rst_n),
        .tdi     (tdi),
        .state   (state),
        .ir_code (ir_code),
        .ir_lsb  (ir_lsb),
        .dr_sel  (dr_sel),
        .hiz     (out_hiz),
        .extest  (ext_drive)
    );

    tap_dr #(
        .BSR_LEN (BSR_LEN),
        .ID_VAL  (ID_VAL)
    ) u_dr (
        .tck      (tck),
        .rst_n    (rst_n),
        .tdi      (tdi),
        .state    (state),
        .dr_sel   (dr_sel),
        .pins_in  (pins_in),
        .dr_lsb   (dr_lsb),
        .pins_out (pins_out)
    );

    always_comb begin
        out_d     = out_q;
        out_d.oe  = (state == TS_SHF_DR) || (state == TS_SHF_IR);
        if (state == TS_SHF_IR)      out_d.tdo = ir_lsb;
        else if (state == TS_SHF_DR) out_d.tdo = dr_lsb;
    end

    always_ff @(negedge tck or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign tdo    = out_q.tdo;
    assign tdo_oe = out_q.oe;

endmodule

// File: rtl/tap_chk.sv
module tap_chk
    import tap_pkg::*;
#(
    parameter int BSR_LEN = 109
) (
    input logic               tck,
    input logic               rst_n,
    input logic               tms,
    input tap_state_e         state,
    input logic [IR_W-1:0]    ir_code,
    input logic               tdo_oe,
    input logic               out_hiz,
    input logic [BSR_LEN-1:0] pins_out
);

    logic [2:0] ones_q;

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n)           ones_q <= '0;
        else if (!tms)        ones_q <= '0;
        else if (ones_q != 5) ones_q <= ones_q + 3'd1;
    end

    // R1
    reset_exit_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (state == TS_RESET && !tms) |=> (state == TS_IDLE));

    // R2
    five_ones_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (ones_q == 3'd5) |-> (state == TS_RESET));

    // R4
    ir_update_chk: assert property (@(posedge tck) disable iff (!rst_n)
        !$stable(ir_code) |-> ($past(state) == TS_UPD_IR || $past(state) == TS_RESET));

    // R6
    hiz_change_chk: assert property (@(posedge tck) disable iff (!rst_n)
        !$stable(out_hiz) |-> ($past(state) == TS_UPD_IR || $past(state) == TS_RESET));

    // R7
    pins_update_chk: assert property (@(posedge tck) disable iff (!rst_n)
        !$stable(pins_out) |-> ($past(state) == TS_UPD_DR));

    // R10
    oe_shift_chk: assert property (@(posedge tck) disable iff (!rst_n)
        tdo_oe == (state == TS_SHF_DR || state == TS_SHF_IR));

endmodule

bind scan_tap_ctrl tap_chk #(.BSR_LEN(BSR_LEN)) u_tap_chk (
    .tck      (tck),
    .rst_n    (rst_n),
    .tms      (tms),
    .state    (state),
    .ir_code  (ir_code),
    .tdo_oe   (tdo_oe),
    .out_hiz  (out_hiz),
    .pins_out (pins_out)
);

// File: tb/scan_tap_ctrl_bench.sv
module scan_tap_ctrl_bench;

    localparam int          BL  = 12;
    localparam logic [31:0] IDV = 32'h1A5C_3E97;

    localparam int S_RST = 0,  S_IDL = 1;
    localparam int S_SDR = 2,  S_CDR = 3,  S_HDR = 4,  S_E1D = 5,  S_PDR = 6,  S_E2D = 7,  S_UDR = 8;
    localparam int S_SIR = 9,  S_CIR = 10, S_HIR = 11, S_E1I = 12, S_PIR = 13, S_E2I = 14, S_UIR = 15;

    logic          tck = 1'b0;
    logic          rst_n = 1'b0;
    logic          tms = 1'b1;
    logic          tdi = 1'b0;
    logic [BL-1:0] pins_in = '0;
    logic          tdo, tdo_oe, out_hiz, ext_drive;
    logic [BL-1:0] pins_out;

    int  n_total = 0;
    int  n_fail  = 0;
    int  mstate  = S_RST;
    bit  done    = 1'b0;

    scan_tap_ctrl #(.BSR_LEN(BL), .ID_VAL(IDV)) u_scan_tap_ctrl (
        .tck(tck), .rst_n(rst_n), .tms(tms), .tdi(tdi), .pins_in(pins_in),
        .tdo(tdo), .tdo_oe(tdo_oe), .pins_out(pins_out),
        .out_hiz(out_hiz), .ext_drive(ext_drive)
    );

    always #4 tck = ~tck;

    function automatic int nxt(input int s, input logic m);
        case (s)
            S_RST: return m ? S_RST : S_IDL;
            S_IDL: return m ? S_SDR : S_IDL;
            S_SDR: return m ? S_SIR : S_CDR;
            S_CDR: return m ? S_E1D : S_HDR;
            S_HDR: return m ? S_E1D : S_HDR;
            S_E1D: return m ? S_UDR : S_PDR;
            S_PDR: return m ? S_E2D : S_PDR;
            S_E2D: return m ? S_UDR : S_HDR;
            S_UDR: return m ? S_SDR : S_IDL;
            S_SIR: return m ? S_RST : S_CIR;
            S_CIR: return m ? S_E1I : S_HIR;
            S_HIR: return m ? S_E1I : S_HIR;
            S_E1I: return m ? S_UIR : S_PIR;
            S_PIR: return m ? S_E2I : S_PIR;
            S_E2I: return m ? S_UIR : S_HIR;
            default: return m ? S_SDR : S_IDL;
        endcase
    endfunction

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input logic m, input logic d, output logic o);
        logic pre;
        tms = m;
        tdi = d;
        pre = tdo;
        @(posedge tck); #1;
        chk("R10 tdo held over rising edge", {127'b0, tdo}, {127'b0, pre});
        @(negedge tck); #1;
        o = tdo;
        mstate = nxt(mstate, m);
        chk("R3 R10 tdo_oe tracks shift states", {127'b0, tdo_oe},
            {127'b0, (mstate == S_HDR || mstate == S_HIR)});
    endtask

    task automatic load_ir(input logic [2:0] c, output logic [2:0] cap);
        logic o;
        step(1, 0, o); step(1, 0, o); step(0, 0, o);
        step(0, 0, o);    cap[0] = o;
        step(0, c[0], o); cap[1] = o;
        step(0, c[1], o); cap[2] = o;
        step(1, c[2], o);
        step(1, 0, o);
        step(0, 0, o);
    endtask

    task automatic scan_dr(input int n, input logic [127:0] din, output logic [127:0] dout);
        logic o;
        dout = '0;
        step(1, 0, o); step(0, 0, o);
        step(0, 0, o); dout[0] = o;
        for (int k = 0; k < n - 1; k++) begin
            step(0, din[k], o);
            dout[k+1] = o;
        end
        step(1, din[n-1], o);
        step(1, 0, o);
        step(0, 0, o);
    endtask

    initial begin
        repeat (150000) @(posedge tck);
        if (!done) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        logic [2:0]   cap;
        logic [127:0] dout;
        logic [127:0] din;
        logic [BL-1:0] prev_out;
        logic         o;

        repeat (3) @(negedge tck);
        #1;
        // R1: reset values
        chk("R1 tdo_oe in reset", {127'b0, tdo_oe}, 128'd0);
        chk("R1 out_hiz in reset", {127'b0, out_hiz}, 128'd0);
        chk("R1 ext_drive in reset", {127'b0, ext_drive}, 128'd0);
        chk("R1 pins_out in reset", {116'b0, pins_out}, 128'd0);
        rst_n = 1'b1;
        step(1, 0, o);
        step(0, 0, o);
        chk("R1 idle after reset exit", mstate, S_IDL);

        // R5 R11: identification is the default instruction
        scan_dr(32, 128'h0, dout);
        chk("R5 R11 default id scan", dout, {96'b0, IDV});

        // Sweep every instruction code
        for (int c = 0; c < 8; c++) begin
            prev_out = pins_out;
            load_ir(c[2:0], cap);
            chk("R4 ir capture pattern", {125'b0, cap}, 128'd1);
            chk("R6 out_hiz per code", {127'b0, out_hiz}, {127'b0, (c == 2)});
            chk("R8 ext_drive per code", {127'b0, ext_drive}, {127'b0, (c == 0)});
            pins_in = BL'((c * 1237 + 2741) & ((1 << BL) - 1));
            din = 128'((c * 911 + 1365) & ((1 << BL) - 1));
            if (c == 1) begin
                scan_dr(32, din, dout);
                chk("R5 id scan via loaded code", dout, {96'b0, IDV});
                chk("R5 pins_out unchanged by id", {116'b0, pins_out}, {116'b0, prev_out});
            end else if (c == 0 || c == 2 || c == 4) begin
                scan_dr(BL, din, dout);
                chk("R6 R7 R8 boundary capture", dout, {116'b0, pins_in});
                chk("R7 boundary update", {116'b0, pins_out}, din);
            end else begin
                scan_dr(9, din, dout);
                chk("R9 bypass delay and zero capture", dout, {119'b0, din[7:0], 1'b0});
                chk("R9 pins_out unchanged by bypass", {116'b0, pins_out}, {116'b0, prev_out});
            end
        end

        // R11: reset path drops a loaded instruction
        load_ir(3'b010, cap);
        chk("R6 hiz while sample-z", {127'b0, out_hiz}, 128'd1);
        for (int k = 0; k < 5; k++) step(1, 0, o);
        chk("R11 hiz cleared by reset state", {127'b0, out_hiz}, 128'd0);
        step(0, 0, o);
        scan_dr(32, 128'h0, dout);
        chk("R11 id after reset state", dout, {96'b0, IDV});

        // R2: five ones from arbitrary states
        for (int t = 0; t < 16; t++) begin
            load_ir(3'b111, cap);
            for (int k = 0; k < t + 3; k++) step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), o);
            for (int k = 0; k < 5; k++) step(1, 0, o);
            chk("R2 model in reset", mstate, S_RST);
            step(0, 0, o);
            scan_dr(32, 128'h0, dout);
            chk("R2 id readable after five ones", dout, {96'b0, IDV});
        end

        // R3: long random walk, tdo_oe checked against model every step
        for (int k = 0; k < 1500; k++) step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), o);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule